// File: doc/BRIEF.md
# Programmable CRC Engine with Input FIFO

This block computes a cyclic redundancy checksum over a stream of data words. Software programs the polynomial taps, the polynomial length (1 to 32 bits), the data word width (8, 16 or 32 bits) and the bit order. It can also load a seed into the result register. It then writes data words into a 128-bit input FIFO. While `start` is high, the engine pops one word at a time into a shift buffer. It pushes the bits of that word through an XOR feedback register at two bits per clock.

The FIFO holds 16, 8 or 4 entries, according to the configured word width. A pulse on `irq` marks one of two events, chosen by a configuration bit. The first is the moment the FIFO gives up its last entry. The second is the moment the last bit of that entry has passed through the engine. Software reads the checksum from the result register once the pulse arrives.

Register map: address 0 is configuration, address 1 is polynomial taps, address 2 is the result, address 3 is the FIFO data port (write only), and address 4 is status. A write to address 4 clears the overflow flag. Reads are combinational from `rd_addr`.

Top module: `crc_engine`

## Requirements
- R1: The polynomial length is CFG[4:0] plus one. Result bits at or above that length read as zero.
- R2: Each data bit d updates the checksum r of length n as follows: the feedback f is r[n-1] xor d, r is shifted left by one, and r is XORed with the polynomial register when f is 1. Each polynomial bit enables its own feedback stage.
- R3: CFG[6:5] selects the data width: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 gives 32 bits. The 128-bit FIFO then holds 16, 8 or 4 entries, and the full flag rises at that entry count.
- R4: When CFG[7] is 1, each word enters the engine starting from bit 0. When it is 0, each word enters starting from its top bit (width minus one).
- R5: The engine takes two bits per clock. With one word queued and the done event selected, `irq` is seen width/2 + 1 clocks after `start` rises.
- R6: CFG[8] selects the interrupt source. A value of 0 gives shift-complete: the last bit of a word leaves the engine while the FIFO is empty. A value of 1 gives FIFO-empty: the pop that removes the last entry. `irq` is a one-cycle pulse, registered one clock after the event.
- R7: The result register at address 2 is writable, and the value written becomes the seed for the next computation.
- R8: A write to the data port while the FIFO is full is dropped and sets sticky status bit 2. A write to address 4 clears that bit.
- R9: Status at address 4 carries empty in bit 0, full in bit 1, overflow in bit 2 and the entry count in bits 8:4. The `fifo_full` and `fifo_empty` ports match status bits 1 and 0.
- R10: While `start` is low, no entry leaves the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| start | input | 1 | Level enable for popping and shifting |
| fifo_full | output | 1 | FIFO holds its maximum entry count |
| fifo_empty | output | 1 | FIFO holds no entries |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with its default 16-byte FIFO and a 3-bit address, so all three FIFO geometries are in use: 16×8, 8×16 and 4×32. That FIFO size lets the bench fill each geometry to full and then overflow it.

Polynomials of length 8, 16 and 32 run in both bit orders at every width. Random lengths from 1 to 32 cover the programmable feedback stages and the masking of the result. Known check values for the nine-byte ASCII string "123456789" tie the bit-serial model to published checksum results.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam logic [2:0] A_CFG  = 3'd0;
  localparam logic [2:0] A_POLY = 3'd1;
  localparam logic [2:0] A_RES  = 3'd2;
  localparam logic [2:0] A_DATA = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;

  // ones in bit positions 0..len_f
  function automatic logic [31:0] len_mask(input logic [4:0] len_f);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++)
      if (i <= int'(len_f)) m[i] = 1'b1;
    return m;
  endfunction

  // one serial step of the feedback register
  function automatic logic [31:0] crc_bit(input logic [31:0] crc, input logic [31:0] poly,
                                          input logic [4:0] len_f, input logic d);
    logic        fb;
    logic [31:0] nx;
    fb = crc[len_f] ^ d;
    nx = {crc[30:0], 1'b0};
    if (fb) nx = nx ^ poly;
    return nx & len_mask(len_f);
  endfunction

  function automatic logic [1:0] wsel_clamp(input logic [1:0] w);
    return (w == 2'd3) ? 2'd2 : w;
  endfunction

  function automatic logic [5:0] width_bits(input logic [1:0] w);
    return 6'd8 << wsel_clamp(w);
  endfunction
endpackage

// File: rtl/crc_fifo.sv
module crc_fifo
  import crc_pkg::*;
#(
  parameter int BYTES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   wsel,
  input  logic                         push,
  input  logic [31:0]                  push_data,
  input  logic                         pop,
  output logic [31:0]                  pop_data,
  output logic [$clog2(BYTES+1)-1:0]   count,
  output logic                         full,
  output logic                         empty,
  output logic                         push_ok
);
  localparam int AW = $clog2(BYTES);
  localparam int CW = $clog2(BYTES + 1);

  logic [7:0]    mem [BYTES];
  logic [AW-1:0] rptr, wptr, step;
  logic [1:0]    ws;
  logic [CW-1:0] depth;
  logic          pop_ok;

  assign ws      = wsel_clamp(wsel);
  assign step    = AW'(1) << ws;
  assign depth   = CW'(BYTES >> ws);
  assign full    = (count == depth);
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_ff @(posedge clk) begin
    if (push_ok)
      for (int j = 0; j < 4; j++)
        if (j < (1 << ws)) mem[wptr + AW'(j)] <= push_data[8*j +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= wptr + step;
      if (pop_ok)  rptr <= rptr + step;
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_comb begin
    for (int j = 0; j < 4; j++)
      pop_data[8*j +: 8] = (j < (1 << ws)) ? mem[rptr + AW'(j)] : 8'h00;
  end
endmodule

// File: rtl/crc_shift.sv
module crc_shift
  import crc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        fifo_empty,
  input  logic        drain,
  input  logic [31:0] pop_data,
  input  logic [1:0]  wsel,
  input  logic        lsb_first,
  input  logic [31:0] poly,
  input  logic [4:0]  len_f,
  input  logic        ld_en,
  input  logic [31:0] ld_val,
  output logic        pop,
  output logic [31:0] crc,
  output logic        busy,
  output logic        last_step,
  output logic        empty_evt,
  output logic        done_evt
);
  logic [5:0]  left, w;
  logic [31:0] sbuf, align, crc_nx;
  logic        b_hi, b_lo;

  assign w         = width_bits(wsel);
  assign pop       = !busy && start && !fifo_empty;
  assign last_step = busy && (left == 6'd2);
  assign empty_evt = pop && drain;
  assign done_evt  = last_step && fifo_empty;

  assign b_hi   = lsb_first ? sbuf[0] : sbuf[31];
  assign b_lo   = lsb_first ? sbuf[1] : sbuf[30];
  assign crc_nx = crc_bit(crc_bit(crc, poly, len_f, b_hi), poly, len_f, b_lo);
  assign align  = lsb_first ? pop_data : (pop_data << (6'd32 - w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      left <= '0;
      sbuf <= '0;
    end else if (pop) begin
      busy <= 1'b1;
      left <= w;
      sbuf <= align;
    end else if (busy) begin
      sbuf <= lsb_first ? (sbuf >> 2) : (sbuf << 2);
      left <= left - 6'd2;
      if (last_step) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc <= '0;
    else if (ld_en)  crc <= ld_val;
    else if (busy)   crc <= crc_nx;
  end
endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_pkg::*;
#(
  parameter int FIFO_BYTES = 16,
  parameter int AW         = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  input  logic          start,
  output logic          fifo_full,
  output logic          fifo_empty,
  output logic          irq
);
  localparam int CW = $clog2(FIFO_BYTES + 1);

  logic [4:0]    len_f;
  logic [1:0]    wsel;
  logic          lsb_first, int_sel, ovf;
  logic [31:0]   poly, crc, pop_data, result_rd, status;
  logic [CW-1:0] count;
  logic          push, push_ok, pop, drain, ovf_clr, ld_en;
  logic          busy, last_step, empty_evt, done_evt;

  assign push    = wr_en && (wr_addr == AW'(A_DATA));
  assign ld_en   = wr_en && (wr_addr == AW'(A_RES));
  assign ovf_clr = wr_en && (wr_addr == AW'(A_STAT));
  assign drain   = (count == CW'(1)) && !push_ok;

  crc_fifo #(.BYTES(FIFO_BYTES)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wsel(wsel), .push(push), .push_data(wr_data),
    .pop(pop), .pop_data(pop_data), .count(count), .full(fifo_full),
    .empty(fifo_empty), .push_ok(push_ok)
  );

  crc_shift u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .fifo_empty(fifo_empty), .drain(drain),
    .pop_data(pop_data), .wsel(wsel), .lsb_first(lsb_first), .poly(poly), .len_f(len_f),
    .ld_en(ld_en), .ld_val(wr_data), .pop(pop), .crc(crc), .busy(busy),
    .last_step(last_step), .empty_evt(empty_evt), .done_evt(done_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_f     <= '0;
      wsel      <= '0;
      lsb_first <= 1'b0;
      int_sel   <= 1'b0;
      poly      <= '0;
      ovf       <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (wr_en && wr_addr == AW'(A_CFG)) begin
        len_f     <= wr_data[4:0];
        wsel      <= wr_data[6:5];
        lsb_first <= wr_data[7];
        int_sel   <= wr_data[8];
      end
      if (wr_en && wr_addr == AW'(A_POLY)) poly <= wr_data;
      if (ovf_clr)                         ovf  <= 1'b0;
      else if (push && fifo_full)          ovf  <= 1'b1;
      irq <= int_sel ? empty_evt : done_evt;
    end
  end

  assign result_rd = crc & len_mask(len_f);

  always_comb begin
    status           = '0;
    status[0]        = fifo_empty;
    status[1]        = fifo_full;
    status[2]        = ovf;
    status[4 +: CW]  = count;
  end

  always_comb begin
    case (rd_addr)
      AW'(A_CFG):  rd_data = {23'd0, int_sel, lsb_first, wsel, len_f};
      AW'(A_POLY): rd_data = poly;
      AW'(A_RES):  rd_data = result_rd;
      AW'(A_STAT): rd_data = status;
      default:     rd_data = '0;
    endcase
  end
endmodule

// File: rtl/crc_engine_sva.sv
module crc_engine_sva
  import crc_pkg::*;
#(
  parameter int CW        = 5,
  parameter int DEPTH_MAX = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic          fifo_full,
  input logic          fifo_empty,
  input logic          push,
  input logic          pop,
  input logic [CW-1:0] count,
  input logic          ovf,
  input logic          ovf_clr,
  input logic          busy,
  input logic          last_step,
  input logic          empty_evt,
  input logic          done_evt,
  input logic [31:0]   result_rd,
  input logic [4:0]    len_f
);
  p_len_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (result_rd & ~len_mask(len_f)) == 32'd0);

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH_MAX);

  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last_step |=> busy);

  p_pop_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !busy);

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(empty_evt || done_evt));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full && push && !pop |=> count == $past(count));

  p_ovf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full && push && !ovf_clr |=> ovf);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf);

  p_flag_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));
endmodule

bind crc_engine crc_engine_sva #(.CW(CW), .DEPTH_MAX(FIFO_BYTES)) u_sva (
  .clk(clk), .rst_n(rst_n), .irq(irq), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
  .push(push), .pop(pop), .count(count), .ovf(ovf), .ovf_clr(ovf_clr), .busy(busy),
  .last_step(last_step), .empty_evt(empty_evt), .done_evt(done_evt),
  .result_rd(result_rd), .len_f(len_f)
);

// File: tb/crc_engine_tb.sv
`timescale 1ns/1ps
module crc_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        start = 1'b0;
  logic        fifo_full, fifo_empty, irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  crc_engine u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .start(start), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bit-serial model: stage i takes stage i-1 plus feedback where tap i is set
  function automatic logic [31:0] ref_crc(input logic [31:0] seed, input logic [31:0] poly,
      input int n, input int w, input bit lsb, input int nw, input logic [31:0] q [16]);
    logic [31:0] r;
    logic [31:0] m;
    logic        fb;
    r = seed;
    for (int k = 0; k < nw; k++)
      for (int b = 0; b < w; b++) begin
        fb = r[n-1] ^ q[k][lsb ? b : (w - 1 - b)];
        for (int i = 31; i >= 1; i--) r[i] = r[i-1] ^ (fb & poly[i]);
        r[0] = fb & poly[0];
      end
    m = '0;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    return r & m;
  endfunction

  function automatic logic [31:0] cfg_word(input int n, input int wsel, input bit lsb, input bit isel);
    return (32'(isel) << 8) | (32'(lsb) << 7) | (32'(wsel) << 5) | 32'(n - 1);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic wait_irq(output int cyc);
    cyc = 0;
    for (int t = 0; t < 400; t++) begin
      @(negedge clk);
      cyc++;
      if (irq) return;
    end
    chk("R6 irq timeout", 32'd0, 32'd1);
  endtask

  task automatic drain();
    @(negedge clk) start = 1'b1;
    repeat (120) @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_case(input string tag, input logic [31:0] poly, input int n,
      input logic [31:0] seed, input int wsel, input bit lsb, input int nw,
      input logic [31:0] q [16], output logic [31:0] act);
    int cyc;
    wr(3'd0, cfg_word(n, wsel, lsb, 1'b0));
    wr(3'd1, poly);
    wr(3'd2, seed);
    for (int k = 0; k < nw; k++) wr(3'd3, q[k]);
    @(negedge clk) start = 1'b1;
    wait_irq(cyc);
    start = 1'b0;
    rd(3'd2, act);
    chk(tag, act, ref_crc(seed, poly, n, 8 << wsel, lsb, nw, q));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R5 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] q [16];
    logic [31:0] polys [3];
    int          lens  [3];
    int          cyc;
    int          seen;
    void'($urandom(32'd7041));
    polys[0] = 32'h07;       lens[0] = 8;
    polys[1] = 32'h1021;     lens[1] = 16;
    polys[2] = 32'h04C11DB7; lens[2] = 32;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk("R6 irq after reset", 32'(irq), 32'd0);
    chk("R9 empty port after reset", 32'(fifo_empty), 32'd1);
    chk("R9 full port after reset", 32'(fifo_full), 32'd0);
    rd(3'd4, v); chk("R9 status after reset", v, 32'h1);
    rd(3'd2, v); chk("R7 result after reset", v, 32'h0);

    // R7 seed write / read back, R1 masking by length
    wr(3'd0, cfg_word(32, 0, 1'b0, 1'b0));
    wr(3'd2, 32'hA5A5_1234);
    rd(3'd2, v); chk("R7 seed readback", v, 32'hA5A5_1234);
    wr(3'd0, cfg_word(8, 0, 1'b0, 1'b0));
    rd(3'd2, v); chk("R1 mask len 8", v, 32'h34);
    wr(3'd0, cfg_word(12, 0, 1'b0, 1'b0));
    rd(3'd2, v); chk("R1 mask len 12", v, 32'h234);
    wr(3'd0, cfg_word(1, 0, 1'b0, 1'b0));
    rd(3'd2, v); chk("R1 mask len 1", v, 32'h0);

    // R2 known check values over ASCII "123456789"
    for (int k = 0; k < 16; k++) q[k] = 32'h31 + 32'(k);
    run_case("R2 crc8", 32'h07, 8, 32'h0, 0, 1'b0, 9, q, v);
    chk("R2 crc8 check value", v, 32'hF4);
    run_case("R2 crc16", 32'h1021, 16, 32'hFFFF, 0, 1'b0, 9, q, v);
    chk("R2 crc16 check value", v, 32'h29B1);
    run_case("R2 crc32", 32'h04C11DB7, 32, 32'hFFFF_FFFF, 0, 1'b0, 9, q, v);
    chk("R2 crc32 check value", v, 32'h0376E6E7);

    // R3 R4 sweep: three polynomials, three widths, both bit orders
    for (int p = 0; p < 3; p++)
      for (int ws = 0; ws < 3; ws++)
        for (int lb = 0; lb < 2; lb++) begin
          int nw;
          nw = 1 + int'($urandom % (16 >> ws));
          for (int k = 0; k < 16; k++) q[k] = $urandom;
          run_case(lb ? "R4 lsb-first sweep" : "R3 msb-first sweep", polys[p], lens[p],
                   $urandom, ws, lb[0], nw, q, v);
        end

    // R2 random lengths and taps
    for (int c = 0; c < 8; c++) begin
      int n;
      n = 1 + int'($urandom % 32);
      for (int k = 0; k < 16; k++) q[k] = $urandom;
      run_case("R2 random length", $urandom | 32'h1, n, $urandom, c % 3, c[0], 3, q, v);
    end

    // R5 two bits per clock
    for (int ws = 0; ws < 3; ws++) begin
      wr(3'd0, cfg_word(16, ws, 1'b0, 1'b0));
      wr(3'd3, 32'h1234_5678);
      @(negedge clk) start = 1'b1;
      wait_irq(cyc);
      start = 1'b0;
      chk("R5 cycles per word", 32'(cyc), 32'((8 << ws) / 2 + 1));
    end

    // R6 fifo-empty source, single pulse
    wr(3'd0, cfg_word(16, 0, 1'b0, 1'b1));
    wr(3'd3, 32'h5A);
    @(negedge clk) start = 1'b1;
    wait_irq(cyc);
    chk("R6 empty event timing", 32'(cyc), 32'd1);
    @(negedge clk);
    chk("R6 pulse width", 32'(irq), 32'd0);
    seen = 0;
    repeat (12) begin @(negedge clk); if (irq) seen++; end
    start = 1'b0;
    chk("R6 no second pulse", 32'(seen), 32'd0);
    wr(3'd3, 32'h11);
    wr(3'd3, 32'h22);
    @(negedge clk) start = 1'b1;
    wait_irq(cyc);
    chk("R6 empty event after two words", 32'(cyc), 32'd6);
    repeat (20) @(negedge clk);
    start = 1'b0;

    // R8 overflow at 32-bit width (4 entries)
    for (int k = 0; k < 16; k++) q[k] = 32'hC0DE_0000 + 32'(k);
    wr(3'd0, cfg_word(32, 2, 1'b0, 1'b0));
    wr(3'd1, 32'h04C11DB7);
    wr(3'd2, 32'hFFFF_FFFF);
    for (int k = 0; k < 5; k++) wr(3'd3, q[k]);
    rd(3'd4, v); chk("R8 full with overflow status", v, 32'h46);
    chk("R9 full port", 32'(fifo_full), 32'd1);
    @(negedge clk) start = 1'b1;
    wait_irq(cyc);
    start = 1'b0;
    rd(3'd2, v);
    chk("R8 dropped word not used", v, ref_crc(32'hFFFF_FFFF, 32'h04C11DB7, 32, 32, 1'b0, 4, q));
    rd(3'd4, v); chk("R8 overflow sticky", v, 32'h5);
    wr(3'd4, 32'h0);
    rd(3'd4, v); chk("R8 overflow cleared", v, 32'h1);

    // R3 depth by width
    wr(3'd0, cfg_word(8, 0, 1'b0, 1'b0));
    for (int k = 0; k < 16; k++) wr(3'd3, 32'(k));
    rd(3'd4, v); chk("R3 depth 16 at 8-bit", v, 32'h102);
    drain();
    wr(3'd0, cfg_word(8, 1, 1'b0, 1'b0));
    for (int k = 0; k < 7; k++) wr(3'd3, 32'(k));
    rd(3'd4, v); chk("R3 not full at 7 of 8", v, 32'h70);
    wr(3'd3, 32'h7);
    rd(3'd4, v); chk("R3 depth 8 at 16-bit", v, 32'h82);
    drain();
    rd(3'd4, v); chk("R9 empty after drain", v, 32'h1);

    // R10 start low holds entries
    wr(3'd0, cfg_word(8, 0, 1'b0, 1'b0));
    wr(3'd3, 32'hAA);
    wr(3'd3, 32'hBB);
    repeat (10) @(negedge clk);
    rd(3'd4, v); chk("R10 no pop while start low", v, 32'h20);
    chk("R10 empty port low", 32'(fifo_empty), 32'd0);
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule